// File: doc/BRIEF.md
# Serial Port Byte Queues with Threshold Interrupts

This block holds the byte queues that sit between a serial frame engine and a processor-side register interface. It has one queue per direction. On the receive side the frame engine writes bytes in and the processor reads them out. On the transmit side the processor writes bytes in and the frame engine reads them out. Both queues hold 32 bytes by default.

Each queue drives an interrupt request. The request compares the queue's fill level against a threshold that a 2-bit code selects. The receive request is active at or above its threshold. The transmit request is active at or below its threshold, so the processor is asked to refill the queue before it runs dry.

A stalled receive stream could leave bytes stranded below the threshold. To catch this, a character timer counts baud ticks while the receive queue holds data and sees no traffic. After four character times it raises the receive request. A byte that arrives while the receive queue is full is lost, and a sticky overrun flag records the loss.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each queue holds DEPTH (32) bytes and returns them in the order written. A read of the head is available combinationally on the read-data output. A push to a full queue is dropped, and a pop from an empty queue is ignored. In both cases the level output is unchanged.
- R2: When a push and a pop reach a queue in the same cycle, a queue that is neither full nor empty accepts both and keeps its level. A full queue performs the pop and drops the pushed byte.
- R3: The receive request is asserted while the receive level is at or above the threshold selected by its code. The code values are 0 = 1 byte, 1 = DEPTH/4 (8), 2 = DEPTH/2 (16) and 3 = DEPTH-2 (30).
- R4: The transmit request is asserted while the transmit level is at or below the threshold selected by its code. The code values are 0 = 0 bytes (empty), 1 = 2 bytes, 2 = DEPTH/4 (8) and 3 = DEPTH/2 (16).
- R5: Both trigger codes are registered and reset to 0. A new code value first affects the requests one clock after the clock edge that samples it.
- R6: A receive push that is dropped because the receive queue is full sets the overrun flag. The flag stays set until an overrun-clear strobe. If a new drop and a clear arrive in the same cycle, the flag ends up set.
- R7: The receive timer counts baud ticks while the receive queue is non-empty and no push or pop is accepted. When the count reaches 4 × char_ticks, the timeout flag sets and the receive request asserts, whatever the level. char_ticks must be nonzero.
- R8: An accepted receive push or pop clears the timeout flag and restarts the count from zero. An empty queue also holds the count at zero.
- R9: After reset both queues are empty with level 0. Overrun and timeout flags are 0, the transmit request is 1 and the receive request is 0.
- R10: A push to a full transmit queue is dropped without touching the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_push | input | 1 | Frame engine writes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Processor reads the receive head |
| rx_rdata | output | 8 | Receive queue head byte |
| rx_level | output | 6 | Receive fill level |
| rx_empty | output | 1 | Receive queue empty |
| tx_push | input | 1 | Processor writes a byte to send |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Frame engine takes the transmit head |
| tx_rdata | output | 8 | Transmit queue head byte |
| tx_level | output | 6 | Transmit fill level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_trig_code | input | 2 | Receive threshold code |
| tx_trig_code | input | 2 | Transmit threshold code |
| baud_tick | input | 1 | One pulse per baud tick |
| char_ticks | input | 16 | Baud ticks per character time |
| ovr_clear | input | 1 | Clears the overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_tmo | output | 1 | Receive timeout flag |
| ovr_flag | output | 1 | Sticky receive overrun flag |

## Verification
The bench sweeps every fill level from 0 to 32 in both queues against all four codes of each threshold. This catches any off-by-one in a threshold or a reversed comparison, which would show up as a request one level early or late. The full-queue cases are a push on full, a push and pop together on full, and an overrun together with a clear. If any of them is wrong, the queue corrupts its order, its level goes past 32, or it loses the sticky flag. The timeout is checked one tick before and at exactly 4 × char_ticks, both from a fresh push and after a restart caused by a pop. A counter that is off by one, or that does not restart, fires on the wrong cycle. Code changes are sampled both before and after the capturing edge, which exposes a threshold that reads the code combinationally.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Receive threshold in bytes for a 2-bit code.
    function automatic int rx_thr(input logic [1:0] code, input int depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    // Transmit threshold in bytes for a 2-bit code.
    function automatic int tx_thr(input logic [1:0] code, input int depth);
        case (code)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return depth / 4;
            default: return depth / 2;
        endcase
    endfunction

endpackage

// File: rtl/ufq_fifo.sv
module ufq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wr;
        logic [AW-1:0]            rd;
        logic [LW-1:0]            lvl;
    } state_t;

    state_t st_d, st_q;
    logic   push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.lvl != LW'(DEPTH));
        pop_ok  = pop && (st_q.lvl != '0);
        if (push_ok) begin
            st_d.mem[st_q.wr] = wdata;
            st_d.wr           = bump(st_q.wr);
        end
        if (pop_ok) begin
            st_d.rd = bump(st_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.mem[st_q.rd];
    assign level = st_q.lvl;
    assign full  = (st_q.lvl == LW'(DEPTH));
    assign empty = (st_q.lvl == '0);

    p_level_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lvl <= LW'(DEPTH));

    p_empty_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (level == '0));

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && pop) |=> (level == LW'(DEPTH - 1)));

endmodule

// File: rtl/ufq_rx_timer.sv
module ufq_rx_timer #(
    parameter int CTW      = 16,
    parameter int TO_CHARS = 4,
    localparam int CW      = CTW + $clog2(TO_CHARS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           empty,
    input  logic           activity,
    input  logic           baud_tick,
    input  logic [CTW-1:0] char_ticks,
    output logic           tmo
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tmo;
    } tstate_t;

    tstate_t ts_d, ts_q;
    logic [CW-1:0] limit;
    logic [CW-1:0] cnt_inc;

    assign limit   = CW'(char_ticks) * CW'(TO_CHARS);
    assign cnt_inc = ts_q.cnt + 1'b1;

    always_comb begin
        ts_d = ts_q;
        if (activity || empty) begin
            ts_d.cnt = '0;
            ts_d.tmo = 1'b0;
        end else if (baud_tick && !ts_q.tmo) begin
            ts_d.cnt = cnt_inc;
            if (cnt_inc >= limit) ts_d.tmo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign tmo = ts_q.tmo;

    p_tmo_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tmo |-> !empty);

    p_activity_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !tmo);

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
    import uart_fifo_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 32,
    parameter int CTW      = 16,
    parameter int TO_CHARS = 4,
    localparam int LW      = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           rx_push,
    input  logic [DW-1:0]  rx_wdata,
    input  logic           rx_pop,
    output logic [DW-1:0]  rx_rdata,
    output logic [LW-1:0]  rx_level,
    output logic           rx_empty,
    input  logic           tx_push,
    input  logic [DW-1:0]  tx_wdata,
    input  logic           tx_pop,
    output logic [DW-1:0]  tx_rdata,
    output logic [LW-1:0]  tx_level,
    output logic           tx_full,
    output logic           tx_empty,
    input  logic [1:0]     rx_trig_code,
    input  logic [1:0]     tx_trig_code,
    input  logic           baud_tick,
    input  logic [CTW-1:0] char_ticks,
    input  logic           ovr_clear,
    output logic           rx_irq,
    output logic           tx_irq,
    output logic           rx_tmo,
    output logic           ovr_flag
);
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       ovr;
    } cstate_t;

    cstate_t cs_d, cs_q;
    logic    rx_full;
    logic    rx_drop;
    logic    rx_act;
    logic [LW-1:0] rx_thr_w, tx_thr_w;

    ufq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop),
        .rdata(rx_rdata), .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    ufq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop),
        .rdata(tx_rdata), .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    assign rx_drop = rx_push && rx_full;
    assign rx_act  = (rx_push && !rx_full) || (rx_pop && !rx_empty);

    ufq_rx_timer #(.CTW(CTW), .TO_CHARS(TO_CHARS)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .empty(rx_empty), .activity(rx_act),
        .baud_tick(baud_tick), .char_ticks(char_ticks),
        .tmo(rx_tmo)
    );

    always_comb begin
        cs_d         = cs_q;
        cs_d.rx_code = rx_trig_code;
        cs_d.tx_code = tx_trig_code;
        if (ovr_clear) cs_d.ovr = 1'b0;
        if (rx_drop)   cs_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign rx_thr_w = LW'(rx_thr(cs_q.rx_code, DEPTH));
    assign tx_thr_w = LW'(tx_thr(cs_q.tx_code, DEPTH));
    assign rx_irq   = (rx_level >= rx_thr_w) || rx_tmo;
    assign tx_irq   = (tx_level <= tx_thr_w);
    assign ovr_flag = cs_q.ovr;

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clear) |=> ovr_flag);

    p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_flag);

    p_tx_empty_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_irq);

    p_tmo_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tmo |-> rx_irq);

    p_rx_one_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_q.rx_code == 2'd0 && !rx_empty) |-> rx_irq);

endmodule

// File: tb/sim_uart_fifo_irq.sv
module sim_uart_fifo_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] rx_wdata = 0, tx_wdata = 0;
    logic [7:0] rx_rdata, tx_rdata;
    logic [5:0] rx_level, tx_level;
    logic       rx_empty, tx_full, tx_empty;
    logic [1:0] rx_trig_code = 0, tx_trig_code = 0;
    logic       baud_tick = 0;
    logic [15:0] char_ticks = 16'd3;
    logic       ovr_clear = 0;
    logic       rx_irq, tx_irq, rx_tmo, ovr_flag;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    uart_fifo_irq u0 (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_level(rx_level), .rx_empty(rx_empty),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_level(tx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_trig_code(rx_trig_code), .tx_trig_code(tx_trig_code),
        .baud_tick(baud_tick), .char_ticks(char_ticks), .ovr_clear(ovr_clear),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_tmo(rx_tmo), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_rx_thr(input int c);
        return (c == 0) ? 1 : (c == 1) ? 32 / 4 : (c == 2) ? 32 / 2 : 32 - 2;
    endfunction

    function automatic int exp_tx_thr(input int c);
        return (c == 0) ? 0 : (c == 1) ? 2 : (c == 2) ? 32 / 4 : 32 / 2;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 rx_level", rx_level, 0);
        chk("R9 tx_level", tx_level, 0);
        chk("R9 rx_irq", rx_irq, 0);
        chk("R9 tx_irq", tx_irq, 1);
        chk("R9 ovr", ovr_flag, 0);
        chk("R9 tmo", rx_tmo, 0);

        // R3 sweep: every level against every code
        for (int lvl = 0; lvl <= 32; lvl++) begin
            for (int c = 0; c < 4; c++) begin
                rx_trig_code = 2'(c);
                step();
                chk("R3 rx_irq", rx_irq, (lvl >= exp_rx_thr(c)) ? 1 : 0);
            end
            chk("R1 rx_level", rx_level, lvl);
            if (lvl < 32) begin
                rx_push = 1; rx_wdata = 8'(lvl + 8'h40);
                step();
                rx_push = 0;
            end
        end

        // R1/R6 push on full: dropped, overrun set
        rx_push = 1; rx_wdata = 8'hEE;
        step();
        rx_push = 0;
        chk("R1 full push level", rx_level, 32);
        chk("R6 overrun set", ovr_flag, 1);
        step();
        chk("R6 overrun sticky", ovr_flag, 1);
        ovr_clear = 1;
        step();
        ovr_clear = 0;
        chk("R6 overrun cleared", ovr_flag, 0);
        rx_push = 1; ovr_clear = 1;
        step();
        rx_push = 0; ovr_clear = 0;
        chk("R6 set wins over clear", ovr_flag, 1);
        ovr_clear = 1;
        step();
        ovr_clear = 0;

        // R2 push and pop on full: pop happens, push lost
        rx_push = 1; rx_wdata = 8'hDD; rx_pop = 1;
        step();
        rx_push = 0; rx_pop = 0;
        chk("R2 full push+pop level", rx_level, 31);
        chk("R2 full push+pop overrun", ovr_flag, 1);
        for (int i = 1; i < 32; i++) begin
            chk("R1 rx order", rx_rdata, i + 8'h40);
            rx_pop = 1;
            step();
            rx_pop = 0;
        end
        chk("R1 rx drained", rx_level, 0);
        rx_pop = 1;
        step();
        rx_pop = 0;
        chk("R1 pop on empty", rx_level, 0);

        // R2 push and pop mid-queue
        rx_push = 1; rx_wdata = 8'h11; step();
        rx_wdata = 8'h22; step();
        rx_wdata = 8'h33; rx_pop = 1; step();
        rx_push = 0; rx_pop = 0;
        chk("R2 mid level", rx_level, 2);
        chk("R2 mid head", rx_rdata, 8'h22);
        rx_pop = 1; step(); rx_pop = 0;
        chk("R2 mid second", rx_rdata, 8'h33);
        rx_pop = 1; step(); rx_pop = 0;

        // R4 sweep
        for (int lvl = 0; lvl <= 32; lvl++) begin
            for (int c = 0; c < 4; c++) begin
                tx_trig_code = 2'(c);
                step();
                chk("R4 tx_irq", tx_irq, (lvl <= exp_tx_thr(c)) ? 1 : 0);
            end
            if (lvl < 32) begin
                tx_push = 1; tx_wdata = 8'(8'hA0 + lvl);
                step();
                tx_push = 0;
            end
        end
        chk("R1 tx full", tx_full, 1);
        // R10 push on full tx
        ovr_clear = 1; step(); ovr_clear = 0;
        tx_push = 1; tx_wdata = 8'h00;
        step();
        tx_push = 0;
        chk("R10 tx level", tx_level, 32);
        chk("R10 no overrun", ovr_flag, 0);
        for (int i = 0; i < 32; i++) begin
            chk("R1 tx order", tx_rdata, 8'hA0 + i);
            tx_pop = 1;
            step();
            tx_pop = 0;
        end
        chk("R1 tx empty", tx_empty, 1);

        // R5 code change takes effect one cycle later
        rx_trig_code = 2'd2;
        for (int i = 0; i < 8; i++) begin
            rx_push = 1; rx_wdata = 8'(i); step();
        end
        rx_push = 0;
        step();
        chk("R5 code2 at 8", rx_irq, 0);
        rx_trig_code = 2'd1;
        #1;
        chk("R5 before capture", rx_irq, 0);
        step();
        chk("R5 after capture", rx_irq, 1);
        for (int i = 0; i < 8; i++) begin
            rx_pop = 1; step();
        end
        rx_pop = 0;

        // R7 timeout from a single byte, code 1
        baud_tick = 1;
        rx_push = 1; rx_wdata = 8'h5A;
        step();
        rx_push = 0;
        repeat (11) step();
        chk("R7 before limit tmo", rx_tmo, 0);
        chk("R7 before limit irq", rx_irq, 0);
        step();
        chk("R7 at limit tmo", rx_tmo, 1);
        chk("R7 at limit irq", rx_irq, 1);
        // R8 restart after push
        rx_push = 1; rx_wdata = 8'h5B;
        step();
        rx_push = 0;
        chk("R8 cleared by push", rx_tmo, 0);
        rx_pop = 1;
        step();
        rx_pop = 0;
        chk("R8 cleared by pop", rx_tmo, 0);
        repeat (11) step();
        chk("R8 restart before", rx_tmo, 0);
        step();
        chk("R8 restart at limit", rx_tmo, 1);
        rx_pop = 1; step(); rx_pop = 0;
        repeat (20) step();
        chk("R8 empty holds", rx_tmo, 0);
        baud_tick = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule